// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Victim Buffer

This block is a small read-only cache for a processor load path. A direct-mapped line array is paired with a small fully-associative victim buffer. Each request is probed against both structures in the same cycle.

A hit in the direct-mapped array answers at once. When the array misses but the victim buffer holds the line, the two lines trade places and the answer comes one cycle later, with no memory traffic. When both structures miss, the block asks memory for the line through a level request / single-cycle response handshake. The line that the fill displaces from the array is then kept in the victim buffer.

The victim buffer is kept in recency order. A newly displaced line always enters as the most recent entry. A line that hits in the buffer leaves it. When the buffer is full, its least recent entry is dropped. Addresses are block addresses, and each line is one word wide.

Top module: `dm_victim_cache`

## Requirements
- R1: After reset no line is valid in either structure. `req_ready` is 1, and `resp_valid` and `mem_req_valid` are 0. The first access to any address is a full miss.
- R2: The array index is the low log2(DM_LINES) bits of the block address, and the remaining upper bits are the stored tag. Two addresses with different low bits never displace each other.
- R3: If a request is accepted (`req_valid` and `req_ready`) and it hits the array, `resp_valid` rises in that same cycle with `resp_hit`=1 and the line. No memory request follows.
- R4: If a request misses the array but hits the victim buffer, the response comes exactly one cycle after acceptance, with `resp_hit`=1 and the line. `mem_req_valid` stays 0.
- R5: On a miss in both structures, `mem_req_valid` rises the cycle after acceptance with `mem_req_addr` equal to the requested address. Both hold until `mem_resp_valid`. The response is given in that same cycle, with `resp_hit`=0 and `mem_resp_data`.
- R6: A memory fill that displaces a valid array line places that line into the victim buffer, so that a later access to it is a victim hit.
- R7: A victim hit swaps lines. Afterwards the requested line hits the array, and the line it displaced (if valid) hits the victim buffer. No line is ever present in both structures.
- R8: The victim buffer holds VB_ENTRIES lines (default 4). An inserted line becomes the most recent, and a victim-hit line leaves the buffer. When a line is inserted into a full buffer, the least recent line is dropped.
- R9: An invalid array line that is displaced is not inserted, so the buffer contents and order stay unchanged.
- R10: `req_ready` is 0 from the acceptance of a victim hit or miss until the cycle of its response.
- R11: `mem_resp_valid` has no effect while no fill is pending. It produces no response, and the array does not fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Requested block address |
| req_ready | output | 1 | Block can accept a request this cycle |
| resp_valid | output | 1 | Response data valid |
| resp_hit | output | 1 | 1 when served on chip, 0 when served by memory |
| resp_data | output | LINE_W | Returned line |
| mem_req_valid | output | 1 | Line fill requested, held until response |
| mem_req_addr | output | ADDR_W | Block address to fetch |
| mem_resp_valid | input | 1 | Fill data present (one cycle) |
| mem_resp_data | input | LINE_W | Fill data |

## Verification
An array hit is due in the cycle the request is driven, and a victim hit in the following cycle. A full miss is due in the cycle the memory responder returns data, three cycles after the request with the bench's fixed responder delay. The bench drives each request just after a falling edge and samples shortly after each later falling edge. It records the first cycle in which `resp_valid` appears and whether a memory request was seen. From that cycle count and `resp_hit` it decides whether the access was an array hit, a victim hit or a miss, and compares the result with the outcome worked out by hand from the access sequence.

// File: rtl/dvc_pkg.sv
package dvc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SWAP = 2'd1,
        ST_FILL = 2'd2
    } dvc_state_e;

endpackage

// File: rtl/dvc_dm_array.sv
module dvc_dm_array #(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 32,
    parameter int LINES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LINE_W-1:0] wr_line,
    output logic              rd_hit,
    output logic              old_valid,
    output logic [ADDR_W-1:0] old_addr,
    output logic [LINE_W-1:0] old_line
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic [LINES-1:0]             valid;
        logic [LINES-1:0][TAG_W-1:0]  tag;
        logic [LINES-1:0][LINE_W-1:0] data;
    } dm_state_t;

    dm_state_t        st_q, st_d;
    logic [IDX_W-1:0] rd_idx, wr_idx;

    assign rd_idx = rd_addr[IDX_W-1:0];
    assign wr_idx = wr_addr[IDX_W-1:0];

    // probe: the line sitting at the request's index
    always_comb begin
        old_valid = st_q.valid[rd_idx];
        old_addr  = {st_q.tag[rd_idx], rd_idx};
        old_line  = st_q.data[rd_idx];
        rd_hit    = old_valid && (st_q.tag[rd_idx] == rd_addr[ADDR_W-1:IDX_W]);
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.valid[wr_idx] = 1'b1;
            st_d.tag[wr_idx]   = wr_addr[ADDR_W-1:IDX_W];
            st_d.data[wr_idx]  = wr_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/dvc_victim_buf.sv
module dvc_victim_buf #(
    parameter int ADDR_W  = 16,
    parameter int LINE_W  = 32,
    parameter int ENTRIES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          probe_addr,
    input  logic                       rm_en,
    input  logic [$clog2(ENTRIES)-1:0] rm_idx,
    input  logic                       ins_en,
    input  logic [ADDR_W-1:0]          ins_addr,
    input  logic [LINE_W-1:0]          ins_line,
    output logic                       hit,
    output logic [$clog2(ENTRIES)-1:0] hit_idx,
    output logic [LINE_W-1:0]          hit_line
);
    localparam int PTR_W = $clog2(ENTRIES);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [LINE_W-1:0] line;
    } vb_entry_t;

    localparam int ENT_W = $bits(vb_entry_t);

    // slot 0 is the most recent, slot ENTRIES-1 the least recent
    typedef struct packed {
        vb_entry_t [ENTRIES-1:0] ent;
    } vb_state_t;

    vb_state_t            st_q, st_d;
    logic [ENTRIES-1:0]   hit_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = st_q.ent[g].valid && (st_q.ent[g].addr == probe_addr);
    end

    always_comb begin
        hit      = |hit_vec;
        hit_idx  = '0;
        hit_line = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                hit_idx  = PTR_W'(i);
                hit_line = st_q.ent[i].line;
            end
        end
    end

    // remove one slot (closing the gap), then optionally push at the front
    always_comb begin
        vb_entry_t [ENTRIES-1:0] closed;
        vb_entry_t [ENTRIES-1:0] pulled;
        vb_entry_t [ENTRIES-1:0] pushed;
        vb_entry_t               fresh;

        pulled = st_q.ent >> ENT_W;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rm_en && (i >= int'(rm_idx))) closed[i] = pulled[i];
            else                              closed[i] = st_q.ent[i];
        end

        fresh.valid = 1'b1;
        fresh.addr  = ins_addr;
        fresh.line  = ins_line;
        pushed      = closed << ENT_W;
        pushed[0]   = fresh;

        st_d.ent = ins_en ? pushed : closed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: fully associative, a block address sits in at most one slot
    assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R9: valid entries stay packed toward the recent end
    for (genvar g = 0; g < ENTRIES - 1; g++) begin : g_packed
        assert_packed_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !st_q.ent[g].valid |-> !st_q.ent[g+1].valid);
    end

endmodule

// File: rtl/dvc_ctrl.sv
module dvc_ctrl
    import dvc_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int LINE_W  = 32,
    parameter int PTR_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [LINE_W-1:0] resp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [LINE_W-1:0] mem_resp_data,
    output logic [ADDR_W-1:0] probe_addr,
    input  logic              dm_hit,
    input  logic              dm_old_valid,
    input  logic [ADDR_W-1:0] dm_old_addr,
    input  logic [LINE_W-1:0] dm_old_line,
    input  logic              vb_hit,
    input  logic [PTR_W-1:0]  vb_hit_idx,
    input  logic [LINE_W-1:0] vb_hit_line,
    output logic              dm_we,
    output logic [ADDR_W-1:0] dm_waddr,
    output logic [LINE_W-1:0] dm_wline,
    output logic              vb_rm_en,
    output logic [PTR_W-1:0]  vb_rm_idx,
    output logic              vb_ins_en,
    output logic [ADDR_W-1:0] vb_ins_addr,
    output logic [LINE_W-1:0] vb_ins_line
);
    typedef struct packed {
        dvc_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [LINE_W-1:0] line;
    } ctrl_state_t;

    ctrl_state_t st_q, st_d;
    logic        accept;

    assign accept = (st_q.state == ST_IDLE) && req_valid;

    always_comb begin
        st_d          = st_q;
        req_ready     = 1'b0;
        resp_valid    = 1'b0;
        resp_hit      = 1'b0;
        resp_data     = '0;
        mem_req_valid = 1'b0;
        mem_req_addr  = st_q.addr;
        probe_addr    = (st_q.state == ST_IDLE) ? req_addr : st_q.addr;
        dm_we         = 1'b0;
        dm_waddr      = probe_addr;
        dm_wline      = '0;
        vb_rm_en      = 1'b0;
        vb_rm_idx     = vb_hit_idx;
        vb_ins_en     = 1'b0;
        vb_ins_addr   = dm_old_addr;
        vb_ins_line   = dm_old_line;

        unique case (st_q.state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (accept) begin
                    if (dm_hit) begin
                        resp_valid = 1'b1;
                        resp_hit   = 1'b1;
                        resp_data  = dm_old_line;
                    end else if (vb_hit) begin
                        // swap: requested line into the array, displaced line to the buffer
                        dm_we      = 1'b1;
                        dm_wline   = vb_hit_line;
                        vb_rm_en   = 1'b1;
                        vb_ins_en  = dm_old_valid;
                        st_d.line  = vb_hit_line;
                        st_d.state = ST_SWAP;
                    end else begin
                        st_d.addr  = req_addr;
                        st_d.state = ST_FILL;
                    end
                end
            end
            ST_SWAP: begin
                resp_valid = 1'b1;
                resp_hit   = 1'b1;
                resp_data  = st_q.line;
                st_d.state = ST_IDLE;
            end
            ST_FILL: begin
                mem_req_valid = 1'b1;
                if (mem_resp_valid) begin
                    resp_valid = 1'b1;
                    resp_data  = mem_resp_data;
                    dm_we      = 1'b1;
                    dm_wline   = mem_resp_data;
                    vb_ins_en  = dm_old_valid;
                    st_d.state = ST_IDLE;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_dm_hit_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && dm_hit |=> req_ready && !mem_req_valid);

    assert_victim_next_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !dm_hit && vb_hit |=> resp_valid && resp_hit && !mem_req_valid);

    assert_fill_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_resp_valid |=> mem_req_valid && $stable(mem_req_addr));

    assert_miss_from_memory_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_hit |-> mem_resp_valid && mem_req_valid);

    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !dm_hit |=> !req_ready);

endmodule

// File: rtl/dm_victim_cache.sv
module dm_victim_cache #(
    parameter int ADDR_W     = 16,
    parameter int LINE_W     = 32,
    parameter int DM_LINES   = 8,
    parameter int VB_ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [LINE_W-1:0] resp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [LINE_W-1:0] mem_resp_data
);
    localparam int PTR_W = $clog2(VB_ENTRIES);

    logic [ADDR_W-1:0] probe_addr;
    logic              dm_hit, dm_old_valid, dm_we;
    logic [ADDR_W-1:0] dm_old_addr, dm_waddr;
    logic [LINE_W-1:0] dm_old_line, dm_wline;
    logic              vb_hit, vb_rm_en, vb_ins_en;
    logic [PTR_W-1:0]  vb_hit_idx, vb_rm_idx;
    logic [LINE_W-1:0] vb_hit_line, vb_ins_line;
    logic [ADDR_W-1:0] vb_ins_addr;

    dvc_dm_array #(
        .ADDR_W (ADDR_W),
        .LINE_W (LINE_W),
        .LINES  (DM_LINES)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (probe_addr),
        .wr_en     (dm_we),
        .wr_addr   (dm_waddr),
        .wr_line   (dm_wline),
        .rd_hit    (dm_hit),
        .old_valid (dm_old_valid),
        .old_addr  (dm_old_addr),
        .old_line  (dm_old_line)
    );

    dvc_victim_buf #(
        .ADDR_W  (ADDR_W),
        .LINE_W  (LINE_W),
        .ENTRIES (VB_ENTRIES)
    ) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .probe_addr (probe_addr),
        .rm_en      (vb_rm_en),
        .rm_idx     (vb_rm_idx),
        .ins_en     (vb_ins_en),
        .ins_addr   (vb_ins_addr),
        .ins_line   (vb_ins_line),
        .hit        (vb_hit),
        .hit_idx    (vb_hit_idx),
        .hit_line   (vb_hit_line)
    );

    dvc_ctrl #(
        .ADDR_W (ADDR_W),
        .LINE_W (LINE_W),
        .PTR_W  (PTR_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_ready      (req_ready),
        .resp_valid     (resp_valid),
        .resp_hit       (resp_hit),
        .resp_data      (resp_data),
        .mem_req_valid  (mem_req_valid),
        .mem_req_addr   (mem_req_addr),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_data  (mem_resp_data),
        .probe_addr     (probe_addr),
        .dm_hit         (dm_hit),
        .dm_old_valid   (dm_old_valid),
        .dm_old_addr    (dm_old_addr),
        .dm_old_line    (dm_old_line),
        .vb_hit         (vb_hit),
        .vb_hit_idx     (vb_hit_idx),
        .vb_hit_line    (vb_hit_line),
        .dm_we          (dm_we),
        .dm_waddr       (dm_waddr),
        .dm_wline       (dm_wline),
        .vb_rm_en       (vb_rm_en),
        .vb_rm_idx      (vb_rm_idx),
        .vb_ins_en      (vb_ins_en),
        .vb_ins_addr    (vb_ins_addr),
        .vb_ins_line    (vb_ins_line)
    );

    // R7: a block lives in the array or in the victim buffer, never both
    assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dm_hit && vb_hit));

    // R11: a memory response with no pending fill yields nothing
    assert_stray_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_resp_valid && !mem_req_valid |-> !resp_valid || resp_hit);

endmodule

// File: tb/dm_victim_cache_tb.sv
module dm_victim_cache_tb;
    localparam int ADDR_W = 16;
    localparam int LINE_W = 32;
    localparam int K_DM   = 0;
    localparam int K_VB   = 1;
    localparam int K_MISS = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready, resp_valid, resp_hit, mem_req_valid;
    logic [LINE_W-1:0] resp_data;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              rsp_r = 1'b0;
    logic              stray = 1'b0;
    logic [LINE_W-1:0] mem_resp_data = '0;
    logic              mem_resp_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    assign mem_resp_valid = rsp_r | stray;

    always #5 clk = ~clk;

    dm_victim_cache u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_ready      (req_ready),
        .resp_valid     (resp_valid),
        .resp_hit       (resp_hit),
        .resp_data      (resp_data),
        .mem_req_valid  (mem_req_valid),
        .mem_req_addr   (mem_req_addr),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_data  (mem_resp_data)
    );

    function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
        return {~a, a};
    endfunction

    // memory responder: data three cycles after the request is driven
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (mem_req_valid && !rsp_r) begin
                logic [ADDR_W-1:0] a;
                a = mem_req_addr;
                repeat (2) @(negedge clk);
                rsp_r         = 1'b1;
                mem_resp_data = line_of(a);
                @(negedge clk);
                rsp_r = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one request; classify by response cycle and memory activity
    task automatic access(input logic [ADDR_W-1:0] a, input int kind, input string req);
        int  cyc;
        bit  got, saw_mem, addr_ok, rdy;
        logic rhit;
        logic [LINE_W-1:0] rdata;
        int exp_cyc;
        cyc = -1; got = 0; saw_mem = 0; addr_ok = 1; rdy = 0; rhit = 0; rdata = '0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        for (int i = 0; i < 20 && !got; i++) begin
            #1;
            if (mem_req_valid) begin
                saw_mem = 1;
                if (mem_req_addr !== a) addr_ok = 0;
            end
            if (resp_valid) begin
                got = 1; cyc = i; rhit = resp_hit; rdata = resp_data; rdy = req_ready;
            end else begin
                @(negedge clk);
                req_valid = 1'b0;
            end
        end
        if (cyc == 0) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
        exp_cyc = (kind == K_DM) ? 0 : (kind == K_VB) ? 1 : 3;
        chk(cyc == exp_cyc, req, $sformatf("response cycle for %h", a), cyc, exp_cyc);
        chk(rhit == (kind != K_MISS) && saw_mem == (kind == K_MISS) && addr_ok, req,
            $sformatf("hit/mem for %h", a), {rhit, saw_mem, addr_ok},
            {kind != K_MISS, kind == K_MISS, 1'b1});
        chk(rdata === line_of(a), req, $sformatf("data for %h", a), rdata, line_of(a));
        if (cyc > 0) chk(rdy == 0, "R10", "ready while busy", rdy, 0);
    endtask

    task automatic t_reset_R1();
        do_reset();
        #1;
        chk(req_ready === 1 && resp_valid === 0 && mem_req_valid === 0, "R1",
            "idle outputs", {req_ready, resp_valid, mem_req_valid}, 3'b100);
        access(16'h0010, K_MISS, "R1");
    endtask

    task automatic t_hit_and_swap();
        access(16'h0010, K_DM,   "R3");
        access(16'h0018, K_MISS, "R5");   // same index: 0x0010 becomes a victim
        access(16'h0011, K_MISS, "R2");
        access(16'h0010, K_VB,   "R6");
        access(16'h0010, K_DM,   "R7");
        access(16'h0018, K_VB,   "R7");
        access(16'h0018, K_DM,   "R4");
        access(16'h0011, K_DM,   "R2");   // other index untouched
    endtask

    task automatic t_lru_R8();
        do_reset();
        access(16'h0002, K_MISS, "R8");
        access(16'h000A, K_MISS, "R8");
        access(16'h0012, K_MISS, "R8");
        access(16'h001A, K_MISS, "R8");
        access(16'h0022, K_MISS, "R8");
        access(16'h002A, K_MISS, "R8");   // 0x02 dropped
        access(16'h0002, K_MISS, "R8");   // 0x0A dropped; buf 2A 22 1A 12
        access(16'h0012, K_VB,   "R8");   // buf 02 2A 22 1A
        access(16'h001A, K_VB,   "R8");   // buf 12 02 2A 22
        access(16'h0032, K_MISS, "R8");   // buf 1A 12 02 2A
        access(16'h0022, K_MISS, "R8");   // buf 32 1A 12 02
        access(16'h0002, K_VB,   "R8");
    endtask

    task automatic t_invalid_victim_R9();
        do_reset();
        access(16'h0005, K_MISS, "R9");
        access(16'h000D, K_MISS, "R9");
        access(16'h0015, K_MISS, "R9");
        access(16'h001D, K_MISS, "R9");
        access(16'h0025, K_MISS, "R9");   // buf 1D 15 0D 05
        access(16'h0003, K_MISS, "R9");   // empty index: nothing inserted
        access(16'h0005, K_VB,   "R9");
    endtask

    task automatic t_stray_R11();
        do_reset();
        @(negedge clk);
        stray = 1'b1;
        mem_resp_data = 32'hDEAD_BEEF;
        #1;
        chk(resp_valid === 0, "R11", "stray response", resp_valid, 0);
        @(negedge clk);
        stray = 1'b0;
        access(16'h0007, K_MISS, "R11");
        access(16'h0007, K_DM,   "R11");
    endtask

    initial begin
        t_reset_R1();
        t_hit_and_swap();
        t_lru_R8();
        t_invalid_victim_R9();
        t_stray_R11();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule